// File: doc/BRIEF.md
# Data Cache Line Maintenance Controller

This block carries out maintenance commands on the tag and state array of a small direct-mapped write-back data cache. Software starts each command by writing one register. It can invalidate or flush a single line, given by a command address, or it can invalidate or flush every line in the cache. A control register holds three bits. The disable bit stops lookups. The invalidate-mode bit selects whether an invalidate discards dirty data or writes it back first. A read-only bit reports that write-backs are still pending. Dirty lines leave the block as line-address requests on a simple request/acknowledge memory port.

Some cache geometries alias, because one way of the cache is larger than a page. For these, the lowest bits of a line command address do not give a byte offset. They supply the extra index bits that the physical address cannot provide. These bits become the top bits of the set index. A line allocator outside the block installs lines through a fill port. A lookup port reports whether an address hits, which also lets the array contents be observed from outside.

The block takes no new register write while a command is in progress. Such a write is held back by the ready output and is not lost.

Top module: `l1_maint_unit`

## Requirements
- R1: After reset no line is valid, the control read value is 0, ready is high and no write-back is requested.
- R2: Register selector codes are: 0 control, 1 line invalidate, 2 line flush, 3 whole-cache invalidate, 4 whole-cache flush. Codes 5 to 7 are ignored. A whole-cache code starts only when write data bit 0 is 1. The control read value has bit 0 = disable, bit 1 = invalidate mode and bit 2 = flush pending, which is read-only.
- R3: For command, fill and lookup addresses, the set index is {addr[ALIAS_W-1:0], addr[OFF_W+PIDX_W-1:OFF_W]} and the tag is addr[ADDR_W-1:OFF_W+PIDX_W]. Address bits [OFF_W-1:ALIAS_W] are ignored.
- R4: A line command whose set is invalid, or whose tag differs, returns to ready one cycle after acceptance. It causes no write-back and leaves the array unchanged.
- R5: With invalidate mode 0, a line invalidate that hits clears the line without a write-back, even when the line is dirty.
- R6: With invalidate mode 1, a line invalidate on a dirty hit issues one write-back to {tag, physical index, zero offset} and clears the line after the acknowledge. A clean hit is cleared without a write-back.
- R7: A line flush on a dirty hit writes the line back and then clears only its dirty bit, so the line stays valid. A flush on a clean hit does nothing.
- R8: A whole-cache command visits every set in ascending index order. It applies the per-line rule for its kind to each valid line, whatever that line's tag.
- R9: The flush-pending bit is high from the acceptance of a flush-type command until that command finishes. Flush-type commands are flushes, and invalidates issued with mode 1. A write-back is requested only while the bit is high.
- R10: Ready is low while a command runs. A register write presented during that time takes effect once ready returns.
- R11: The disable bit forces the lookup hit output low. The array contents are kept and hit again once the bit is cleared.
- R12: A write-back request holds with a stable address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register selector |
| reg_wdata_i | input | ADDR_W | Write data or line command address |
| reg_ready_o | output | 1 | Write accepted this cycle when high |
| ctrl_rdata_o | output | 3 | {flush pending, invalidate mode, disable} |
| fill_i | input | 1 | Install a line |
| fill_addr_i | input | ADDR_W | Address of the installed line |
| fill_dirty_i | input | 1 | Dirty state of the installed line |
| look_addr_i | input | ADDR_W | Lookup address |
| look_hit_o | output | 1 | Lookup hits a valid line |
| look_dirty_o | output | 1 | Hit line is dirty |
| wb_req_o | output | 1 | Write-back request |
| wb_addr_o | output | ADDR_W | Line address being written back |
| wb_ack_i | input | 1 | Write-back complete |

## Verification
The checks assume that the fill port is used only while ready is high, so that the allocator never races a maintenance walk. They also assume that the acknowledge is raised only while a request is present. The stimulus drives fills only after it has seen ready high at a falling edge. Its memory responder acknowledges only a request it has already observed, after a short delay, and drops the acknowledge on the next falling edge. Register writes keep selector and data constant until they are accepted.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL      = 3'd0,
    SEL_LINE_INV  = 3'd1,
    SEL_LINE_FLSH = 3'd2,
    SEL_ALL_INV   = 3'd3,
    SEL_ALL_FLSH  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WB
  } eng_state_e;

  localparam int CTRL_DIS   = 0;
  localparam int CTRL_IMODE = 1;
  localparam int CTRL_PEND  = 2;
endpackage

// File: rtl/cmu_addr_split.sv
module cmu_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 5,
  parameter int IDX_W   = 4,
  parameter int ALIAS_W = 1,
  localparam int PIDX_W = IDX_W - ALIAS_W,
  localparam int TAG_W  = ADDR_W - OFF_W - PIDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  // alias bits ride in the line-offset field and become the top index bits
  assign idx_o = {addr_i[ALIAS_W-1:0], addr_i[OFF_W+PIDX_W-1:OFF_W]};
  assign tag_o = addr_i[ADDR_W-1:OFF_W+PIDX_W];

  logic unused_offset;
  assign unused_offset = ^addr_i[OFF_W-1:ALIAS_W];
endmodule

// File: rtl/cmu_tag_array.sv
module cmu_tag_array #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 24,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic             rd_a_valid_o,
  output logic             rd_a_dirty_o,
  output logic [TAG_W-1:0] rd_a_tag_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic             rd_b_valid_o,
  output logic             rd_b_dirty_o,
  output logic [TAG_W-1:0] rd_b_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic             wr_dirty_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic             valid_q [SETS];
  logic             dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic hit_wr;
    assign hit_wr = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (hit_wr) begin
        valid_q[g] <= wr_valid_i;
        dirty_q[g] <= wr_dirty_i;
        tag_q[g]   <= wr_tag_i;
      end
    end
  end

  assign rd_a_valid_o = valid_q[rd_a_idx_i];
  assign rd_a_dirty_o = dirty_q[rd_a_idx_i];
  assign rd_a_tag_o   = tag_q[rd_a_idx_i];
  assign rd_b_valid_o = valid_q[rd_b_idx_i];
  assign rd_b_dirty_o = dirty_q[rd_b_idx_i];
  assign rd_b_tag_o   = tag_q[rd_b_idx_i];
endmodule

// File: rtl/cmu_engine.sv
module cmu_engine
  import cmu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 4,
  parameter int PIDX_W = 3,
  localparam int TAG_W = ADDR_W - OFF_W - PIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              all_i,
  input  logic              kill_i,
  input  logic              wb_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [IDX_W-1:0]  arr_idx_o,
  input  logic              arr_valid_i,
  input  logic              arr_dirty_i,
  input  logic [TAG_W-1:0]  arr_tag_i,
  output logic              wr_en_o,
  output logic              wr_valid_o,
  output logic              wr_dirty_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  input  logic              wb_ack_i,
  output logic              idle_o,
  output logic              flushing_o
);
  eng_state_e       state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [TAG_W-1:0] tag_q;
  logic             all_q, kill_q, wb_q;
  logic             hit, advance;

  assign hit = arr_valid_i && (all_q || (arr_tag_i == tag_q));

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    wr_en_o    = 1'b0;
    wr_valid_o = arr_valid_i;
    wr_dirty_o = arr_dirty_i;
    advance    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CHECK;
          ptr_d   = all_i ? '0 : idx_i;
        end
      end
      ST_CHECK: begin
        if (!hit) begin
          advance = 1'b1;
        end else if (wb_q && arr_dirty_i) begin
          state_d = ST_WB;
        end else begin
          if (kill_q) begin
            wr_en_o    = 1'b1;
            wr_valid_o = 1'b0;
            wr_dirty_o = 1'b0;
          end
          advance = 1'b1;
        end
      end
      ST_WB: begin
        if (wb_ack_i) begin
          wr_en_o    = 1'b1;
          wr_valid_o = !kill_q;
          wr_dirty_o = 1'b0;
          advance    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (advance) begin
      if (all_q && (ptr_q != '1)) begin
        ptr_d   = ptr_q + IDX_W'(1);
        state_d = ST_CHECK;
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      tag_q   <= '0;
      all_q   <= 1'b0;
      kill_q  <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      if (state_q == ST_IDLE && start_i) begin
        tag_q  <= tag_i;
        all_q  <= all_i;
        kill_q <= kill_i;
        wb_q   <= wb_i;
      end
    end
  end

  assign arr_idx_o  = ptr_q;
  assign wb_req_o   = (state_q == ST_WB);
  assign wb_addr_o  = {arr_tag_i, ptr_q[PIDX_W-1:0], {OFF_W{1'b0}}};
  assign idle_o     = (state_q == ST_IDLE);
  assign flushing_o = !idle_o && wb_q;

  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_addr_o)); // R12
  AST_MISS_QUICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK) && !hit && !all_q |=> idle_o); // R4
  AST_WB_DIRTY_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> arr_valid_i && arr_dirty_i); // R7
  AST_FLUSH_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !kill_q |-> wr_valid_o && !wr_dirty_o); // R7
endmodule

// File: rtl/l1_maint_unit.sv
module l1_maint_unit
  import cmu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 5,
  parameter int IDX_W   = 4,
  parameter int ALIAS_W = 1,
  localparam int PIDX_W = IDX_W - ALIAS_W,
  localparam int TAG_W  = ADDR_W - OFF_W - PIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic              reg_ready_o,
  output logic [2:0]        ctrl_rdata_o,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic              fill_dirty_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              look_hit_o,
  output logic              look_dirty_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  input  logic              wb_ack_i
);
  reg_sel_e         sel;
  logic             idle, flushing, accept, ctrl_we, start, is_all, is_inv;
  logic             dis_q, imode_q;
  logic [IDX_W-1:0] cmd_idx, fill_idx, look_idx, eng_idx, wr_idx;
  logic [TAG_W-1:0] cmd_tag, fill_tag, look_tag, a_tag, b_tag, wr_tag;
  logic             a_valid, a_dirty, b_valid, b_dirty;
  logic             eng_wr, eng_v, eng_d, fill_we, wr_en, wr_valid, wr_dirty;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign accept  = reg_wr_i && idle;
  assign ctrl_we = accept && (sel == SEL_CTRL);
  assign is_all  = (sel == SEL_ALL_INV) || (sel == SEL_ALL_FLSH);
  assign is_inv  = (sel == SEL_LINE_INV) || (sel == SEL_ALL_INV);
  assign start   = accept && ((sel == SEL_LINE_INV) || (sel == SEL_LINE_FLSH) ||
                              (is_all && reg_wdata_i[0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q   <= 1'b0;
      imode_q <= 1'b0;
    end else if (ctrl_we) begin
      dis_q   <= reg_wdata_i[CTRL_DIS];
      imode_q <= reg_wdata_i[CTRL_IMODE];
    end
  end

  cmu_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ALIAS_W(ALIAS_W))
    u_cmd_split (.addr_i(reg_wdata_i), .idx_o(cmd_idx), .tag_o(cmd_tag));
  cmu_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ALIAS_W(ALIAS_W))
    u_fill_split (.addr_i(fill_addr_i), .idx_o(fill_idx), .tag_o(fill_tag));
  cmu_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ALIAS_W(ALIAS_W))
    u_look_split (.addr_i(look_addr_i), .idx_o(look_idx), .tag_o(look_tag));

  cmu_engine #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PIDX_W(PIDX_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .all_i      (is_all),
    .kill_i     (is_inv),
    .wb_i       (!is_inv || imode_q),
    .idx_i      (cmd_idx),
    .tag_i      (cmd_tag),
    .arr_idx_o  (eng_idx),
    .arr_valid_i(a_valid),
    .arr_dirty_i(a_dirty),
    .arr_tag_i  (a_tag),
    .wr_en_o    (eng_wr),
    .wr_valid_o (eng_v),
    .wr_dirty_o (eng_d),
    .wb_req_o   (wb_req_o),
    .wb_addr_o  (wb_addr_o),
    .wb_ack_i   (wb_ack_i),
    .idle_o     (idle),
    .flushing_o (flushing)
  );

  assign fill_we  = fill_i && idle;
  assign wr_en    = eng_wr || fill_we;
  assign wr_idx   = eng_wr ? eng_idx : fill_idx;
  assign wr_valid = eng_wr ? eng_v : 1'b1;
  assign wr_dirty = eng_wr ? eng_d : fill_dirty_i;
  assign wr_tag   = eng_wr ? a_tag : fill_tag;

  cmu_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_a_idx_i  (eng_idx),
    .rd_a_valid_o(a_valid),
    .rd_a_dirty_o(a_dirty),
    .rd_a_tag_o  (a_tag),
    .rd_b_idx_i  (look_idx),
    .rd_b_valid_o(b_valid),
    .rd_b_dirty_o(b_dirty),
    .rd_b_tag_o  (b_tag),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_valid_i  (wr_valid),
    .wr_dirty_i  (wr_dirty),
    .wr_tag_i    (wr_tag)
  );

  assign look_hit_o   = !dis_q && b_valid && (b_tag == look_tag);
  assign look_dirty_o = look_hit_o && b_dirty;
  assign reg_ready_o  = idle;
  assign ctrl_rdata_o = {flushing, imode_q, dis_q};

  AST_PEND_COVERS_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> ctrl_rdata_o[CTRL_PEND]); // R9
  AST_CTRL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_ready_o |=> $stable(dis_q) && $stable(imode_q)); // R10
  AST_FILL_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> reg_ready_o); // R10
  AST_DIS_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |-> !look_hit_o); // R11
endmodule

// File: tb/sim_l1_maint_unit.sv
module sim_l1_maint_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready;
  logic [2:0]  ctrl_rd;
  logic        fill = 1'b0;
  logic [31:0] fill_addr = '0;
  logic        fill_dirty = 1'b0;
  logic [31:0] look_addr = '0;
  logic        look_hit, look_dirty;
  logic        wb_req;
  logic [31:0] wb_addr;
  logic        wb_ack = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  l1_maint_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_ready_o(reg_ready), .ctrl_rdata_o(ctrl_rd),
    .fill_i(fill), .fill_addr_i(fill_addr), .fill_dirty_i(fill_dirty),
    .look_addr_i(look_addr), .look_hit_o(look_hit), .look_dirty_o(look_dirty),
    .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_ack_i(wb_ack)
  );

  // tag [31:8], physical index [7:5], ignored [4:1], alias bit [0]
  function automatic logic [31:0] mk(logic [23:0] t, logic [2:0] p, logic a, logic [3:0] j = 4'h0);
    return {t, p, j, a};
  endfunction
  function automatic logic [31:0] wba(logic [23:0] t, logic [2:0] p);
    return {t, p, 5'b0};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!reg_ready) @(negedge clk);
  endtask

  task automatic do_fill(logic [31:0] a, logic d);
    wait_idle();
    fill = 1'b1; fill_addr = a; fill_dirty = d;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic look(string req, logic [31:0] a, logic h, logic d);
    wait_idle();
    look_addr = a;
    #1;
    check(req, "hit", {31'b0, look_hit}, {31'b0, h});
    check(req, "dirty", {31'b0, look_dirty}, {31'b0, d});
  endtask

  task automatic drained(string req);
    wait_idle();
    check(req, "pending write-backs", exp_q.size(), 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // monitor: memory responder and write-back scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (wb_req) begin
        logic [31:0] first;
        first = wb_addr;
        check("R9", "pending during write-back", {31'b0, ctrl_rd[2]}, 32'd1);
        if (exp_q.size() == 0) begin
          check("R6 R7 R8", "unexpected write-back", first, 32'hFFFF_FFFF);
        end else begin
          check("R6 R7 R8", "write-back address", first, exp_q.pop_front());
        end
        @(negedge clk);
        check("R12", "request held", {31'b0, wb_req}, 32'd1);
        check("R12", "address stable", wb_addr, first);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready", {31'b0, reg_ready}, 32'd1);
    check("R1", "ctrl", {29'b0, ctrl_rd}, 32'd0);
    check("R1", "wb_req", {31'b0, wb_req}, 32'd0);
    look("R1", mk(24'h0, 3'd0, 1'b0), 1'b0, 1'b0);

    // R7 flush of a clean line
    do_fill(mk(24'h000111, 3'd2, 1'b0), 1'b0);
    look("R3", mk(24'h000111, 3'd2, 1'b0), 1'b1, 1'b0);
    wr_reg(3'd2, mk(24'h000111, 3'd2, 1'b0));
    drained("R7");
    look("R7", mk(24'h000111, 3'd2, 1'b0), 1'b1, 1'b0);

    // R7 flush of a dirty line
    do_fill(mk(24'h000222, 3'd3, 1'b0), 1'b1);
    exp_q.push_back(wba(24'h000222, 3'd3));
    wr_reg(3'd2, mk(24'h000222, 3'd3, 1'b0));
    drained("R7");
    look("R7", mk(24'h000222, 3'd3, 1'b0), 1'b1, 1'b0);

    // R5 discard invalidate of a dirty line
    do_fill(mk(24'h000222, 3'd3, 1'b0), 1'b1);
    wr_reg(3'd1, mk(24'h000222, 3'd3, 1'b0));
    drained("R5");
    look("R5", mk(24'h000222, 3'd3, 1'b0), 1'b0, 1'b0);

    // R4 tag miss: one busy cycle
    wait_idle();
    reg_wr = 1'b1; reg_sel = 3'd1; reg_wdata = mk(24'h000999, 3'd2, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0;
    check("R4", "busy after accept", {31'b0, reg_ready}, 32'd0);
    @(negedge clk);
    check("R4", "ready one cycle later", {31'b0, reg_ready}, 32'd1);
    drained("R4");
    look("R4", mk(24'h000111, 3'd2, 1'b0), 1'b1, 1'b0);

    // R3 alias bit selects the set, offset bits ignored
    do_fill(mk(24'h000333, 3'd5, 1'b0), 1'b0);
    do_fill(mk(24'h000333, 3'd5, 1'b1), 1'b0);
    wr_reg(3'd1, mk(24'h000333, 3'd5, 1'b1, 4'hF));
    drained("R3");
    look("R3", mk(24'h000333, 3'd5, 1'b1), 1'b0, 1'b0);
    look("R3", mk(24'h000333, 3'd5, 1'b0, 4'hA), 1'b1, 1'b0);

    // R6 invalidate with write-back mode
    wr_reg(3'd0, 32'd2);
    wait_idle();
    check("R2", "ctrl mode readback", {29'b0, ctrl_rd}, 32'd2);
    do_fill(mk(24'h000444, 3'd6, 1'b1), 1'b1);
    exp_q.push_back(wba(24'h000444, 3'd6));
    wr_reg(3'd1, mk(24'h000444, 3'd6, 1'b1));
    drained("R6");
    look("R6", mk(24'h000444, 3'd6, 1'b1), 1'b0, 1'b0);
    do_fill(mk(24'h000555, 3'd7, 1'b1), 1'b0);
    wr_reg(3'd1, mk(24'h000555, 3'd7, 1'b1));
    drained("R6");
    look("R6", mk(24'h000555, 3'd7, 1'b1), 1'b0, 1'b0);

    // R8 whole invalidate, discard mode
    wr_reg(3'd0, 32'd0);
    wr_reg(3'd3, 32'd1);
    drained("R8");
    look("R8", mk(24'h000111, 3'd2, 1'b0), 1'b0, 1'b0);
    look("R8", mk(24'h000333, 3'd5, 1'b0), 1'b0, 1'b0);

    // R8 R9 R10 whole flush, ascending order, held-off ctrl write
    do_fill(mk(24'h0000A1, 3'd1, 1'b0), 1'b1);
    do_fill(mk(24'h0000B6, 3'd6, 1'b0), 1'b1);
    do_fill(mk(24'h0000C4, 3'd4, 1'b1), 1'b1);
    do_fill(mk(24'h0000D1, 3'd1, 1'b1), 1'b0);
    exp_q.push_back(wba(24'h0000A1, 3'd1));
    exp_q.push_back(wba(24'h0000B6, 3'd6));
    exp_q.push_back(wba(24'h0000C4, 3'd4));
    wr_reg(3'd4, 32'd1);
    check("R9", "pending after start", {31'b0, ctrl_rd[2]}, 32'd1);
    check("R10", "busy during walk", {31'b0, reg_ready}, 32'd0);
    wr_reg(3'd0, 32'd1);
    check("R10", "held write after walk", exp_q.size(), 0);
    wait_idle();
    check("R10", "disable applied", {29'b0, ctrl_rd}, 32'd1);
    look("R11", mk(24'h0000A1, 3'd1, 1'b0), 1'b0, 1'b0);
    wr_reg(3'd0, 32'd0);
    look("R11", mk(24'h0000A1, 3'd1, 1'b0), 1'b1, 1'b0);
    look("R8", mk(24'h0000C4, 3'd4, 1'b1), 1'b1, 1'b0);
    look("R8", mk(24'h0000D1, 3'd1, 1'b1), 1'b1, 1'b0);

    // R8 R6 whole flush-and-invalidate
    wr_reg(3'd0, 32'd2);
    do_fill(mk(24'h0000E3, 3'd3, 1'b0), 1'b1);
    exp_q.push_back(wba(24'h0000E3, 3'd3));
    wr_reg(3'd3, 32'd1);
    drained("R8");
    check("R9", "pending cleared", {31'b0, ctrl_rd[2]}, 32'd0);
    look("R8", mk(24'h0000A1, 3'd1, 1'b0), 1'b0, 1'b0);
    look("R8", mk(24'h0000E3, 3'd3, 1'b0), 1'b0, 1'b0);
    look("R8", mk(24'h0000D1, 3'd1, 1'b1), 1'b0, 1'b0);

    // R2 ignored writes
    wr_reg(3'd0, 32'd0);
    do_fill(mk(24'h0000F2, 3'd2, 1'b0), 1'b0);
    wr_reg(3'd3, 32'd0);
    check("R2", "zero data does not start", {31'b0, reg_ready}, 32'd1);
    look("R2", mk(24'h0000F2, 3'd2, 1'b0), 1'b1, 1'b0);
    wr_reg(3'd5, 32'hFFFF_FFFF);
    check("R2", "unused code ready", {31'b0, reg_ready}, 32'd1);
    check("R2", "unused code ctrl", {29'b0, ctrl_rd}, 32'd0);
    look("R2", mk(24'h0000F2, 3'd2, 1'b0), 1'b1, 1'b0);

    repeat (4) @(negedge clk);
    report();
  end
endmodule